// File: doc/BRIEF.md
# Pointer Address Generator with Dual-Channel Post-Update

This block computes the memory addresses a DSP-style core uses for its data operands. It keeps eight register groups. Each group holds a pointer, a step (offset) and an arithmetic-kind selector (modifier). An instruction names only the pointer number. The step and the selector with that same number are used with it, with no further encoding. Two address channels, X and Y, can each issue an address in the same cycle. Each channel has its own pointer, step and selector. The pointer is post-updated at the clock edge that ends the instruction.

Each clock cycle is one instruction slot. Software reaches all 24 registers through a move write port and a direct read port. A move is staged for one slot before it lands in the register file. The instruction right after a move therefore still sees the old value as a pointer, and the second instruction after it sees the new value. The selector decides the update arithmetic:
- all ones gives plain linear arithmetic;
- a value from 1 up to a parameter limit gives a circular buffer of that value plus one;
- zero gives reverse-carry arithmetic for bit-reversed access.

Top module: `agu_core`

## Requirements
- R1: After a synchronous active-low reset, every pointer and every step register reads zero, and every selector register reads 0xFFFFFFFF.
- R2: The read port returns the register picked by `rd_kind` (0 = pointer, 1 = step, 2 = selector) and `rd_idx`. Kind 3 reads zero.
- R3: A move presented in slot t is invisible to address generation and to the read port in slot t+1. It becomes visible in slot t+2. This holds for pointer, step and selector moves.
- R4: The channel mode codes behave as follows. 0 outputs Rn with no update. 1 outputs Rn and adds 1. 2 outputs Rn and subtracts 1. 3 outputs Rn and adds Nn. 4 outputs Rn and subtracts Nn. 5 outputs Rn+Nn and leaves Rn unchanged. 6 and 7 act as mode 0.
- R5: An access through pointer n always uses step n and selector n.
- R6: When a selector value M is between 1 and the modulo limit, all updates and indexed addresses stay inside a buffer of M+1 words. The buffer base is the pointer with its low k bits cleared, where 2^k is the smallest power of two of at least M+1.
- R7: A selector value of zero makes the add or subtract use reverse carry, i.e. rev(rev(Rn) ± rev(step)) over 32 bits.
- R8: Channels X and Y generate addresses and update two different pointers in the same cycle, each with its own selector.
- R9: When a staged move lands on the same pointer a channel updates at that edge, the move wins. When both channels update the same pointer, channel X wins.
- R10: A channel whose enable is low changes no register, whatever its mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one instruction slot per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Move write request for this slot |
| wr_kind | input | 2 | Move target kind: 0 pointer, 1 step, 2 selector, 3 none |
| wr_idx | input | 3 | Move target register number |
| wr_data | input | 32 | Move data |
| rd_kind | input | 2 | Read kind, same coding as wr_kind |
| rd_idx | input | 3 | Read register number |
| rd_data | output | 32 | Committed contents of the selected register |
| x_en | input | 1 | Channel X performs its post-update at the edge |
| x_mode | input | 3 | Channel X mode code |
| x_idx | input | 3 | Channel X pointer number |
| x_addr | output | 32 | Channel X effective address |
| y_en | input | 1 | Channel Y performs its post-update at the edge |
| y_mode | input | 3 | Channel Y mode code |
| y_idx | input | 3 | Channel Y pointer number |
| y_addr | output | 32 | Channel Y effective address |

## Verification
Two things can land on the same pointer at one clock edge. The first is a move that was staged in the previous slot. The second is a channel post-update, from one channel or from both channels aimed at one pointer. The bench issues a move to a pointer and then runs a post-increment on that pointer in the next slot. It checks that the address in that slot is the old value and that the register afterwards holds the moved value, not the incremented one. It then points both channels at one pointer with opposite updates. It checks through the read port that only channel X's result remains.

// File: rtl/agu_pkg.sv
// Package agu_pkg
// Shared encodings for the address generator: register kinds for the
// move and read ports, and channel addressing mode codes.
package agu_pkg;

    typedef enum logic [1:0] {
        KIND_PTR  = 2'd0,
        KIND_STEP = 2'd1,
        KIND_SEL  = 2'd2,
        KIND_NONE = 2'd3
    } reg_kind_e;

    typedef enum logic [2:0] {
        AM_HOLD  = 3'd0,
        AM_INC1  = 3'd1,
        AM_DEC1  = 3'd2,
        AM_INCN  = 3'd3,
        AM_DECN  = 3'd4,
        AM_INDEX = 3'd5,
        AM_RSV6  = 3'd6,
        AM_RSV7  = 3'd7
    } amode_e;

endpackage

// File: rtl/agu_modarith.sv
// Module agu_modarith
// Purely combinational address adder. Adds or subtracts a magnitude
// to a pointer under one of three arithmetic kinds picked by the
// selector value: all ones = linear, 1..MOD_LIMIT = circular buffer
// of size sel+1, zero = reverse-carry. Other selector values fall
// back to linear.
// Assumes: in circular mode the magnitude does not exceed the buffer
// size and the pointer already lies inside its buffer.
module agu_modarith #(
    parameter int DW        = 32,
    parameter int MOD_LIMIT = 32767
) (
    input  logic [DW-1:0] base_ptr,
    input  logic [DW-1:0] mag,
    input  logic          sub,
    input  logic [DW-1:0] sel,
    output logic [DW-1:0] res
);

    localparam logic [DW-1:0] ALL_ONES = {DW{1'b1}};
    localparam logic [DW-1:0] MOD_MAX  = DW'(MOD_LIMIT);

    // Bit-reverse a word.
    function automatic logic [DW-1:0] rev(input logic [DW-1:0] v);
        logic [DW-1:0] o;
        for (int i = 0; i < DW; i++) o[i] = v[DW-1-i];
        return o;
    endfunction

    // Fill every bit below the highest set bit: gives 2^k-1 >= v.
    function automatic logic [DW-1:0] smear(input logic [DW-1:0] v);
        logic [DW-1:0] o;
        o = v;
        for (int s = 1; s < DW; s = s * 2) o = o | (o >> s);
        return o;
    endfunction

    logic          is_mod;
    logic          is_rev;
    logic [DW-1:0] mask;
    logic [DW-1:0] buf_base;
    logic [DW-1:0] off;
    logic [DW:0]   off_sum;
    logic [DW:0]   buf_len;
    logic [DW-1:0] mod_off;
    logic [DW-1:0] rev_sum;
    logic [DW-1:0] lin_sum;

    // Classify the selector value.
    always_comb begin
        is_rev = (sel == '0);
        is_mod = (sel != '0) && (sel <= MOD_MAX) && (sel != ALL_ONES);
    end

    // Circular-buffer arithmetic: work on the offset, wrap once.
    always_comb begin
        mask     = smear(sel);
        buf_base = base_ptr & ~mask;
        off      = base_ptr & mask;
        buf_len  = {1'b0, sel} + 1'b1;
        off_sum  = '0;
        mod_off  = '0;
        if (!sub) begin
            off_sum = {1'b0, off} + {1'b0, mag};
            if (off_sum > {1'b0, sel}) off_sum = off_sum - buf_len;
            mod_off = off_sum[DW-1:0];
        end else begin
            if (mag > off) off_sum = {1'b0, off} + buf_len - {1'b0, mag};
            else           off_sum = {1'b0, off} - {1'b0, mag};
            mod_off = off_sum[DW-1:0];
        end
    end

    // Reverse-carry and linear sums.
    always_comb begin
        rev_sum = sub ? rev(rev(base_ptr) - rev(mag)) : rev(rev(base_ptr) + rev(mag));
        lin_sum = sub ? (base_ptr - mag) : (base_ptr + mag);
    end

    // Pick the result for the selector kind.
    always_comb begin
        if (is_rev)      res = rev_sum;
        else if (is_mod) res = buf_base | mod_off;
        else             res = lin_sum;
    end

    // R6: a circular result stays inside the pointer's buffer.
    always_comb begin
        if (is_mod && (mag <= sel + 1'b1) && (off <= sel)) begin
            p_mod_in_buf_r6: assert (((res & ~mask) == buf_base) && ((res & mask) <= sel))
                else $error("circular result left its buffer");
        end
    end

endmodule

// File: rtl/agu_regfile.sv
// Module agu_regfile
// Holds the eight pointer, step and selector registers. A move is
// staged one slot and lands at the following edge, so it becomes
// visible two slots after it was issued. Per-channel post-updates land
// at each edge. Write order at one edge: channel Y, then channel X,
// then the staged move (last one wins).
// Assumes: one instruction slot per clock cycle.
module agu_regfile
    import agu_pkg::*;
#(
    parameter int DW   = 32,
    parameter int NREG = 8,
    parameter int NCH  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [1:0]              wr_kind,
    input  logic [$clog2(NREG)-1:0] wr_idx,
    input  logic [DW-1:0]           wr_data,
    input  logic [1:0]              rd_kind,
    input  logic [$clog2(NREG)-1:0] rd_idx,
    output logic [DW-1:0]           rd_data,
    input  logic [NCH-1:0]                   upd_en,
    input  logic [NCH-1:0][$clog2(NREG)-1:0] upd_idx,
    input  logic [NCH-1:0][DW-1:0]           upd_val,
    input  logic [NCH-1:0][$clog2(NREG)-1:0] ptr_idx,
    output logic [NCH-1:0][DW-1:0]           ptr_r,
    output logic [NCH-1:0][DW-1:0]           ptr_n,
    output logic [NCH-1:0][DW-1:0]           ptr_m
);

    localparam int IW = $clog2(NREG);

    logic [DW-1:0] r_q [NREG];
    logic [DW-1:0] n_q [NREG];
    logic [DW-1:0] m_q [NREG];

    logic          stg_vld;
    reg_kind_e     stg_kind;
    logic [IW-1:0] stg_idx;
    logic [DW-1:0] stg_data;

    // Stage an incoming move for one slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_vld  <= 1'b0;
            stg_kind <= KIND_NONE;
            stg_idx  <= '0;
            stg_data <= '0;
        end else begin
            stg_vld  <= wr_en && (reg_kind_e'(wr_kind) != KIND_NONE);
            stg_kind <= reg_kind_e'(wr_kind);
            stg_idx  <= wr_idx;
            stg_data <= wr_data;
        end
    end

    // Apply post-updates (Y then X) and the staged move, last wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                r_q[i] <= '0;
                n_q[i] <= '0;
                m_q[i] <= '1;
            end
        end else begin
            for (int c = NCH - 1; c >= 0; c--) begin
                if (upd_en[c]) r_q[upd_idx[c]] <= upd_val[c];
            end
            if (stg_vld) begin
                case (stg_kind)
                    KIND_PTR:  r_q[stg_idx] <= stg_data;
                    KIND_STEP: n_q[stg_idx] <= stg_data;
                    KIND_SEL:  m_q[stg_idx] <= stg_data;
                    default:   ;
                endcase
            end
        end
    end

    // Direct read of the committed register.
    always_comb begin
        case (reg_kind_e'(rd_kind))
            KIND_PTR:  rd_data = r_q[rd_idx];
            KIND_STEP: rd_data = n_q[rd_idx];
            KIND_SEL:  rd_data = m_q[rd_idx];
            default:   rd_data = '0;
        endcase
    end

    // Per-channel operand fetch; step and selector share the pointer index.
    for (genvar c = 0; c < NCH; c++) begin : g_fetch
        always_comb begin
            ptr_r[c] = r_q[ptr_idx[c]];
            ptr_n[c] = n_q[ptr_idx[c]];
            ptr_m[c] = m_q[ptr_idx[c]];
        end
    end

    // R3: a staged pointer move lands at the next edge.
    p_move_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stg_vld && stg_kind == KIND_PTR) |=> r_q[$past(stg_idx)] == $past(stg_data))
        else $error("staged move did not land");

    // R3: a fresh pointer move is not yet visible one edge later.
    p_move_hidden_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind == 2'd0
         && !(upd_en[0] && upd_idx[0] == wr_idx)
         && !(upd_en[1] && upd_idx[1] == wr_idx)
         && !(stg_vld && stg_kind == KIND_PTR && stg_idx == wr_idx))
        |=> r_q[$past(wr_idx)] == $past(r_q[wr_idx]))
        else $error("move visible too early");

    // R9: with both channels on one pointer and no move, X's value remains.
    p_x_over_y_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en[0] && upd_en[1] && upd_idx[0] == upd_idx[1]
         && !(stg_vld && stg_kind == KIND_PTR && stg_idx == upd_idx[0]))
        |=> r_q[$past(upd_idx[0])] == $past(upd_val[0]))
        else $error("channel X lost same-pointer collision");

    // R10: with no update and no move, pointers hold.
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en == '0 && !stg_vld) |=> r_q[$past(rd_idx)] == $past(r_q[rd_idx]))
        else $error("pointer changed without cause");

endmodule

// File: rtl/agu_core.sv
// Module agu_core
// Top of the address generator. Two channels (X = 0, Y = 1) decode
// their mode code into a magnitude and direction, run the shared
// arithmetic under the selector of the same pointer number, drive the
// effective address and request a post-update.
// Assumes: one instruction slot per clock cycle; mode codes per agu_pkg.
module agu_core
    import agu_pkg::*;
#(
    parameter int DW        = 32,
    parameter int NREG      = 8,
    parameter int MOD_LIMIT = 32767
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [1:0]              wr_kind,
    input  logic [$clog2(NREG)-1:0] wr_idx,
    input  logic [DW-1:0]           wr_data,
    input  logic [1:0]              rd_kind,
    input  logic [$clog2(NREG)-1:0] rd_idx,
    output logic [DW-1:0]           rd_data,
    input  logic                    x_en,
    input  logic [2:0]              x_mode,
    input  logic [$clog2(NREG)-1:0] x_idx,
    output logic [DW-1:0]           x_addr,
    input  logic                    y_en,
    input  logic [2:0]              y_mode,
    input  logic [$clog2(NREG)-1:0] y_idx,
    output logic [DW-1:0]           y_addr
);

    localparam int NCH = 2;
    localparam int IW  = $clog2(NREG);

    logic [NCH-1:0]          ch_en;
    logic [NCH-1:0][2:0]     ch_mode;
    logic [NCH-1:0][IW-1:0]  ch_idx;
    logic [NCH-1:0][DW-1:0]  ch_addr;
    logic [NCH-1:0]          upd_en;
    logic [NCH-1:0][DW-1:0]  upd_val;
    logic [NCH-1:0][DW-1:0]  ptr_r;
    logic [NCH-1:0][DW-1:0]  ptr_n;
    logic [NCH-1:0][DW-1:0]  ptr_m;

    // Gather the channel ports into arrays.
    always_comb begin
        ch_en   = {y_en, x_en};
        ch_mode = {y_mode, x_mode};
        ch_idx  = {y_idx, x_idx};
        x_addr  = ch_addr[0];
        y_addr  = ch_addr[1];
    end

    agu_regfile #(
        .DW   (DW),
        .NREG (NREG),
        .NCH  (NCH)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_kind (wr_kind),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_kind (rd_kind),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .upd_en  (upd_en),
        .upd_idx (ch_idx),
        .upd_val (upd_val),
        .ptr_idx (ch_idx),
        .ptr_r   (ptr_r),
        .ptr_n   (ptr_n),
        .ptr_m   (ptr_m)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [DW-1:0] mag;
        logic          sub;
        logic          wants_upd;
        logic [DW-1:0] sum;

        // Decode the mode code into magnitude, direction and update need.
        always_comb begin
            mag       = '0;
            sub       = 1'b0;
            wants_upd = 1'b0;
            case (amode_e'(ch_mode[c]))
                AM_INC1:  begin mag = DW'(1); wants_upd = 1'b1; end
                AM_DEC1:  begin mag = DW'(1); sub = 1'b1; wants_upd = 1'b1; end
                AM_INCN:  begin mag = ptr_n[c]; wants_upd = 1'b1; end
                AM_DECN:  begin mag = ptr_n[c]; sub = 1'b1; wants_upd = 1'b1; end
                AM_INDEX: mag = ptr_n[c];
                default:  ;
            endcase
        end

        agu_modarith #(
            .DW        (DW),
            .MOD_LIMIT (MOD_LIMIT)
        ) u_arith (
            .base_ptr (ptr_r[c]),
            .mag      (mag),
            .sub      (sub),
            .sel      (ptr_m[c]),
            .res      (sum)
        );

        // Effective address and post-update request.
        always_comb begin
            ch_addr[c] = (amode_e'(ch_mode[c]) == AM_INDEX) ? sum : ptr_r[c];
            upd_en[c]  = ch_en[c] && wants_upd;
            upd_val[c] = sum;
        end
    end

endmodule

// File: tb/agu_core_tb.sv
// Directed bench for agu_core: one task per scenario.
module agu_core_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_kind = 2'd3;
    logic [2:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_kind = 2'd0;
    logic [2:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic        x_en = 1'b0;
    logic [2:0]  x_mode = '0;
    logic [2:0]  x_idx = '0;
    logic [31:0] x_addr;
    logic        y_en = 1'b0;
    logic [2:0]  y_mode = '0;
    logic [2:0]  y_idx = '0;
    logic [31:0] y_addr;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    agu_core dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_kind(rd_kind), .rd_idx(rd_idx), .rd_data(rd_data),
        .x_en(x_en), .x_mode(x_mode), .x_idx(x_idx), .x_addr(x_addr),
        .y_en(y_en), .y_mode(y_mode), .y_idx(y_idx), .y_addr(y_addr)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic clr();
        wr_en = 1'b0; wr_kind = 2'd3;
        x_en = 1'b0; x_mode = 3'd0;
        y_en = 1'b0; y_mode = 3'd0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Move and wait until it is visible (two slots).
    task automatic put(input logic [1:0] k, input logic [2:0] i, input logic [31:0] d);
        wr_en = 1'b1; wr_kind = k; wr_idx = i; wr_data = d;
        step();
        clr();
        step();
    endtask

    task automatic rdchk(input string tag, input logic [1:0] k, input logic [2:0] i,
                         input logic [31:0] exp);
        rd_kind = k; rd_idx = i;
        #1;
        chk(tag, rd_data, exp);
    endtask

    // One X-channel instruction: check address, then apply.
    task automatic xop(input string tag, input logic [2:0] i, input logic [2:0] m,
                       input logic [31:0] exp_addr);
        x_en = 1'b1; x_idx = i; x_mode = m;
        #1;
        chk(tag, x_addr, exp_addr);
        step();
        clr();
    endtask

    task automatic t_reset();
        for (int i = 0; i < 8; i++) begin
            rdchk("R1 ptr reset", 2'd0, 3'(i), 32'h0);
            rdchk("R1 step reset", 2'd1, 3'(i), 32'h0);
            rdchk("R1 sel reset", 2'd2, 3'(i), 32'hFFFF_FFFF);
        end
        put(2'd1, 3'd4, 32'h55);
        rdchk("R2 read step", 2'd1, 3'd4, 32'h55);
        rdchk("R2 kind 3 reads zero", 2'd3, 3'd4, 32'h0);
    endtask

    task automatic t_hazard();
        wr_en = 1'b1; wr_kind = 2'd0; wr_idx = 3'd2; wr_data = 32'h100;
        step();
        clr();
        x_idx = 3'd2; x_mode = 3'd0;
        rdchk("R3 read old after move", 2'd0, 3'd2, 32'h0);
        chk("R3 pointer old one slot after move", x_addr, 32'h0);
        step();
        x_idx = 3'd2; x_mode = 3'd0;
        #1;
        chk("R3 pointer new two slots after move", x_addr, 32'h100);
        wr_en = 1'b1; wr_kind = 2'd1; wr_idx = 3'd2; wr_data = 32'h4;
        step();
        clr();
        x_idx = 3'd2; x_mode = 3'd5;
        #1;
        chk("R3 step old one slot after move", x_addr, 32'h100);
        step();
        x_idx = 3'd2; x_mode = 3'd5;
        #1;
        chk("R3 step new two slots after move", x_addr, 32'h104);
    endtask

    task automatic t_linear();
        put(2'd0, 3'd1, 32'h10);
        put(2'd1, 3'd1, 32'h3);
        xop("R4 inc1 addr", 3'd1, 3'd1, 32'h10);
        xop("R4 dec1 addr", 3'd1, 3'd2, 32'h11);
        xop("R4 incN addr", 3'd1, 3'd3, 32'h10);
        xop("R4 decN addr", 3'd1, 3'd4, 32'h13);
        xop("R4 index addr", 3'd1, 3'd5, 32'h13);
        xop("R4 mode 6 no update", 3'd1, 3'd6, 32'h10);
        xop("R4 hold no update", 3'd1, 3'd0, 32'h10);
        rdchk("R4 pointer after sequence", 2'd0, 3'd1, 32'h10);
    endtask

    task automatic t_bind();
        put(2'd0, 3'd3, 32'h200);
        put(2'd1, 3'd3, 32'h8);
        put(2'd1, 3'd4, 32'h50);
        xop("R5 step of same index", 3'd3, 3'd3, 32'h200);
        rdchk("R5 updated by own step", 2'd0, 3'd3, 32'h208);
    endtask

    task automatic t_modulo();
        put(2'd2, 3'd5, 32'd9);
        put(2'd0, 3'd5, 32'h48);
        put(2'd1, 3'd5, 32'd4);
        xop("R6 inc1 from 0x48", 3'd5, 3'd1, 32'h48);
        xop("R6 inc1 from 0x49", 3'd5, 3'd1, 32'h49);
        xop("R6 wrapped to base", 3'd5, 3'd2, 32'h40);
        xop("R6 dec1 wrapped to top", 3'd5, 3'd3, 32'h49);
        xop("R6 incN wrapped", 3'd5, 3'd4, 32'h43);
        xop("R6 decN wrapped back", 3'd5, 3'd5, 32'h43);
        rdchk("R6 index leaves pointer", 2'd0, 3'd5, 32'h49);
    endtask

    task automatic t_bitrev();
        put(2'd2, 3'd6, 32'h0);
        put(2'd1, 3'd6, 32'h8);
        xop("R7 start", 3'd6, 3'd3, 32'h0);
        xop("R7 rev step 1", 3'd6, 3'd3, 32'h8);
        xop("R7 rev step 2", 3'd6, 3'd4, 32'h4);
        rdchk("R7 rev decrement", 2'd0, 3'd6, 32'h8);
    endtask

    task automatic t_dual();
        put(2'd0, 3'd0, 32'h20);
        x_en = 1'b1; x_idx = 3'd0; x_mode = 3'd1;
        y_en = 1'b1; y_idx = 3'd5; y_mode = 3'd1;
        #1;
        chk("R8 dual x addr", x_addr, 32'h20);
        chk("R8 dual y addr", y_addr, 32'h49);
        step();
        clr();
        rdchk("R8 x linear update", 2'd0, 3'd0, 32'h21);
        rdchk("R8 y circular update", 2'd0, 3'd5, 32'h40);
    endtask

    task automatic t_collide();
        put(2'd0, 3'd7, 32'h300);
        wr_en = 1'b1; wr_kind = 2'd0; wr_idx = 3'd7; wr_data = 32'h500;
        step();
        clr();
        xop("R9 old addr during staging", 3'd7, 3'd1, 32'h300);
        rdchk("R9 move beats post-update", 2'd0, 3'd7, 32'h500);
        x_en = 1'b1; x_idx = 3'd7; x_mode = 3'd1;
        y_en = 1'b1; y_idx = 3'd7; y_mode = 3'd2;
        #1;
        chk("R9 y sees same pointer", y_addr, 32'h500);
        step();
        clr();
        rdchk("R9 x beats y", 2'd0, 3'd7, 32'h501);
    endtask

    task automatic t_disabled();
        x_en = 1'b0; x_idx = 3'd7; x_mode = 3'd3;
        y_en = 1'b0; y_idx = 3'd0; y_mode = 3'd1;
        step();
        clr();
        rdchk("R10 disabled x no change", 2'd0, 3'd7, 32'h501);
        rdchk("R10 disabled y no change", 2'd0, 3'd0, 32'h21);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        clr();
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_hazard();
        t_linear();
        t_bind();
        t_modulo();
        t_bitrev();
        t_dual();
        t_collide();
        t_disabled();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule